// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent page translations for 4 KB pages. Each cycle a requester may present a virtual address and say whether the access is a read or a write. Every stored entry compares its virtual page number with the request at once. One cycle later the block returns the result. On a hit it gives the physical address, formed from the stored physical page number and the untouched 12-bit page offset. On a miss it raises a miss flag and changes nothing, so the access can be replayed once software or an outside agent has installed the missing translation.

Every entry carries two status bits. The used bit records that the page has been touched. The dirty bit records that the page has been written. A hit sets these bits, and the response reports their values from before that access. The installer writes a complete entry in one cycle through the refill pins. The entry it replaces is the lowest-numbered invalid one if any exists, and otherwise the least recently used one. A refill counts as a use, and so does a lookup hit. A flush input drops every translation in a single cycle.

The lookup path has no ready signal and no back-pressure. A request is taken in every cycle that `lk_valid` is high, and the response must be consumed in the cycle it appears. The refill path is likewise accepted in every cycle, except during a flush.

Top module: `tlb_fa`

## Requirements
- R1: A lookup presented with `lk_valid` high gets its response exactly one cycle later with `rsp_valid` high. On a hit, `rsp_pa` equals the stored physical page number concatenated with `lk_va[11:0]`.
- R2: All entries are searched in parallel. A request hits whichever valid entry holds its virtual page number, regardless of that entry's position, and all 16 entries can hold live translations at once.
- R3: On a miss, `rsp_miss` is 1, `rsp_hit` is 0, and `rsp_pa`, `rsp_used` and `rsp_dirty` are 0. A miss changes no entry, no status bit and no replacement order.
- R4: A hit sets the entry's used bit. `rsp_used` reports the bit as it was before the access, so the first hit after a refill with used=0 reports 0 and later hits report 1.
- R5: A write hit (`lk_write`=1) sets the entry's dirty bit, and a read hit leaves it unchanged. `rsp_dirty` reports the bit as it was before the access.
- R6: While any entry is invalid, a refill goes into the lowest-numbered invalid entry, so no valid translation is lost.
- R7: When all entries are valid, a refill replaces the entry that has gone longest without a refill or a lookup hit.
- R8: A refill whose virtual page number is already present overwrites that entry, including its physical page number and both status bits, instead of creating a duplicate.
- R9: While `flush` is high, all entries become invalid at the next edge. A lookup in that cycle misses, and a refill in that cycle is dropped.
- R10: When a refill and a lookup arrive in the same cycle, the refill is applied first. A lookup of the refilled page hits, and it reports the status bits given on the refill pins.
- R11: After reset, `rsp_valid`, `rsp_hit` and `rsp_miss` are 0 and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is a write (1) or a read (0) |
| lk_va | input | VA_W | Virtual address of the lookup |
| rf_valid | input | 1 | Refill request present |
| rf_vpn | input | VA_W-12 | Virtual page number to install |
| rf_ppn | input | PA_W-12 | Physical page number to install |
| rf_used | input | 1 | Initial used bit |
| rf_dirty | input | 1 | Initial dirty bit |
| rsp_valid | output | 1 | Response present (one cycle after a lookup) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent; retry after refill |
| rsp_pa | output | PA_W | Physical address on hit, zero on miss |
| rsp_used | output | 1 | Used bit before this access |
| rsp_dirty | output | 1 | Dirty bit before this access |

## Verification
The assertions check the following properties on every cycle. A response follows each request by exactly one cycle. A hit passes the page offset through. A miss returns a zero address. A lookup during a flush always misses. The replacement ages always name exactly one oldest entry. The victim chooser never picks a valid entry while an invalid one exists. Other behaviours need the bench's sequences to show them: which translation a refill actually evicts, how the status bits build up over a read, a write and a later read, overwriting a page that is already present, and the order of a refill and a lookup that arrive in the same cycle. All of these depend on history across many cycles.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic used;
    logic dirty;
  } tlb_stat_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N  = 16,
  parameter int KW = 20,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vld,
  input  logic [KW-1:0] keys [N],
  input  logic [KW-1:0] key,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] match;

  // one comparator per entry
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (keys[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) idx = IW'(i);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t1_en,
  input  logic [IW-1:0] t1_idx,
  input  logic          t2_en,
  input  logic [IW-1:0] t2_idx,
  output logic [N-1:0]  oldest
);
  // age 0 = most recent, N-1 = least recent; ages form a permutation
  logic [IW-1:0] age_q [N];
  logic [IW-1:0] mid   [N];
  logic [IW-1:0] fin   [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mid[i] = age_q[i];
      if (t1_en) begin
        if (IW'(i) == t1_idx)             mid[i] = '0;
        else if (age_q[i] < age_q[t1_idx]) mid[i] = age_q[i] + IW'(1);
      end
    end
    for (int i = 0; i < N; i++) begin
      fin[i] = mid[i];
      if (t2_en) begin
        if (IW'(i) == t2_idx)          fin[i] = '0;
        else if (mid[i] < mid[t2_idx]) fin[i] = mid[i] + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else begin
      for (int i = 0; i < N; i++) age_q[i] <= fin[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (age_q[g] == IW'(N-1));
  end

  assert_single_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);

  assert_touched_not_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    t2_en |=> !oldest[$past(t2_idx)]);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic [N-1:0]  oldest,
  output logic [IW-1:0] idx
);
  logic full;
  assign full = &vld;

  always_comb begin
    idx = '0;
    if (full) begin
      for (int i = 0; i < N; i++)
        if (oldest[i]) idx = IW'(i);
    end else begin
      for (int i = N-1; i >= 0; i--)
        if (!vld[i]) idx = IW'(i);
    end
  end

  assert_victim_invalid_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !vld[idx]);

  assert_victim_is_lru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> oldest[idx]);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    lk_valid,
  input  logic                    lk_write,
  input  logic [VA_W-1:0]         lk_va,
  input  logic                    rf_valid,
  input  logic [VA_W-PG_BITS-1:0] rf_vpn,
  input  logic [PA_W-PG_BITS-1:0] rf_ppn,
  input  logic                    rf_used,
  input  logic                    rf_dirty,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic                    rsp_miss,
  output logic [PA_W-1:0]         rsp_pa,
  output logic                    rsp_used,
  output logic                    rsp_dirty
);
  localparam int VPN_W = VA_W - PG_BITS;
  localparam int PPN_W = PA_W - PG_BITS;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  tlb_stat_t          st_q  [ENTRIES];

  // post-refill view seen by the lookup
  logic [ENTRIES-1:0] eff_vld;
  logic [VPN_W-1:0]   eff_vpn [ENTRIES];
  logic [PPN_W-1:0]   eff_ppn [ENTRIES];
  tlb_stat_t          eff_st  [ENTRIES];

  logic [VPN_W-1:0]   lk_vpn;
  logic               rf_any, lk_any, rf_go, lk_hit;
  logic [IW-1:0]      rf_hidx, vic_idx, rf_idx, lk_idx;
  logic [ENTRIES-1:0] oldest;

  assign lk_vpn = lk_va[VA_W-1:PG_BITS];
  assign rf_go  = rf_valid && !flush;

  tlb_cam #(.N(ENTRIES), .KW(VPN_W), .IW(IW)) u_cam_rf (
    .vld(vld_q), .keys(vpn_q), .key(rf_vpn), .any(rf_any), .idx(rf_hidx)
  );

  tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .clk(clk), .rst_n(rst_n), .vld(vld_q), .oldest(oldest), .idx(vic_idx)
  );

  assign rf_idx = rf_any ? rf_hidx : vic_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (rf_go && rf_idx == IW'(i)) begin
        eff_vld[i] = 1'b1;
        eff_vpn[i] = rf_vpn;
        eff_ppn[i] = rf_ppn;
        eff_st[i]  = '{used: rf_used, dirty: rf_dirty};
      end else begin
        eff_vld[i] = vld_q[i];
        eff_vpn[i] = vpn_q[i];
        eff_ppn[i] = ppn_q[i];
        eff_st[i]  = st_q[i];
      end
    end
  end

  tlb_cam #(.N(ENTRIES), .KW(VPN_W), .IW(IW)) u_cam_lk (
    .vld(eff_vld), .keys(eff_vpn), .key(lk_vpn), .any(lk_any), .idx(lk_idx)
  );

  assign lk_hit = lk_valid && !flush && lk_any;

  tlb_lru #(.N(ENTRIES), .IW(IW)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .t1_en(rf_go),  .t1_idx(rf_idx),
    .t2_en(lk_hit), .t2_idx(lk_idx),
    .oldest(oldest)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        ppn_q[i] <= '0;
        st_q[i]  <= '0;
      end
    end else if (flush) begin
      vld_q <= '0;
    end else begin
      if (rf_go) begin
        vld_q[rf_idx] <= 1'b1;
        vpn_q[rf_idx] <= rf_vpn;
        ppn_q[rf_idx] <= rf_ppn;
        st_q[rf_idx]  <= '{used: rf_used, dirty: rf_dirty};
      end
      if (lk_hit)
        st_q[lk_idx] <= '{used: 1'b1, dirty: eff_st[lk_idx].dirty | lk_write};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
      rsp_used  <= 1'b0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_miss  <= lk_valid && !lk_hit;
      rsp_pa    <= lk_hit ? {eff_ppn[lk_idx], lk_va[PG_BITS-1:0]} : '0;
      rsp_used  <= lk_hit && eff_st[lk_idx].used;
      rsp_dirty <= lk_hit && eff_st[lk_idx].dirty;
    end
  end

  assert_rsp_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_no_rsp_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  assert_offset_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !flush) |=> (!rsp_hit || rsp_pa[PG_BITS-1:0] == $past(lk_va[PG_BITS-1:0])));

  assert_miss_zero_pa_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == '0 && !rsp_hit && !rsp_used && !rsp_dirty));

  assert_flush_lookup_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && lk_valid) |=> rsp_miss);
endmodule

// File: tb/tlb_fa_test.sv
`timescale 1ns/1ps
module tlb_fa_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_write = 1'b0;
  logic [31:0] lk_va = '0;
  logic        rf_valid = 1'b0;
  logic [19:0] rf_vpn = '0;
  logic [19:0] rf_ppn = '0;
  logic        rf_used = 1'b0;
  logic        rf_dirty = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_used, rsp_dirty;
  logic [31:0] rsp_pa;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  tlb_fa uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_write(lk_write), .lk_va(lk_va),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .rf_used(rf_used), .rf_dirty(rf_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_pa(rsp_pa), .rsp_used(rsp_used), .rsp_dirty(rsp_dirty)
  );

  typedef struct packed {
    logic        refill;
    logic        wr;
    logic [19:0] vpn;
    logic [11:0] off;
    logic [19:0] ppn;
    logic        hit;
    logic        used;
    logic        dirty;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b0, 20'h00010, 12'h004, 20'h00000, 1'b0, 1'b0, 1'b0}, // R3 cold miss
    '{1'b1, 1'b0, 20'h00010, 12'h000, 20'h0ABCD, 1'b0, 1'b0, 1'b0}, // refill
    '{1'b0, 1'b0, 20'h00010, 12'h123, 20'h0ABCD, 1'b1, 1'b0, 1'b0}, // R1 R4 first hit
    '{1'b0, 1'b1, 20'h00010, 12'hFFF, 20'h0ABCD, 1'b1, 1'b1, 1'b0}, // R5 write
    '{1'b0, 1'b0, 20'h00010, 12'h000, 20'h0ABCD, 1'b1, 1'b1, 1'b1}, // R5 dirty seen
    '{1'b1, 1'b0, 20'h00020, 12'h000, 20'h12345, 1'b0, 1'b1, 1'b1}, // refill with status
    '{1'b0, 1'b0, 20'h00020, 12'h456, 20'h12345, 1'b1, 1'b1, 1'b1}, // R4 initial bits
    '{1'b0, 1'b0, 20'h00021, 12'h010, 20'h00000, 1'b0, 1'b0, 1'b0}, // R3 neighbour miss
    '{1'b1, 1'b0, 20'h00010, 12'h000, 20'h0BBBB, 1'b0, 1'b0, 1'b0}, // R8 overwrite
    '{1'b0, 1'b0, 20'h00010, 12'h789, 20'h0BBBB, 1'b1, 1'b0, 1'b0}  // R8 new mapping
  };

  task automatic cyc(input logic l, input logic w, input logic [31:0] va,
                     input logic r, input logic [19:0] rv, input logic [19:0] rp,
                     input logic ru, input logic rd, input logic f);
    @(negedge clk);
    lk_valid = l; lk_write = w; lk_va = va;
    rf_valid = r; rf_vpn = rv; rf_ppn = rp; rf_used = ru; rf_dirty = rd;
    flush = f;
    @(negedge clk);
    lk_valid = 0; lk_write = 0; rf_valid = 0; flush = 0;
  endtask

  task automatic chk(input string req, input logic eh, input logic [19:0] ep,
                     input logic [11:0] off, input logic eu, input logic ed);
    logic [31:0] epa;
    epa = eh ? {ep, off} : 32'h0;
    n_chk++;
    if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_miss !== !eh || rsp_pa !== epa ||
        rsp_used !== (eh & eu) || rsp_dirty !== (eh & ed)) begin
      n_bad++;
      $display("FAIL %s: got v=%b h=%b m=%b pa=%h u=%b d=%b exp v=1 h=%b m=%b pa=%h u=%b d=%b",
               req, rsp_valid, rsp_hit, rsp_miss, rsp_pa, rsp_used, rsp_dirty,
               eh, !eh, epa, eh & eu, eh & ed);
    end
  endtask

  task automatic look(input string req, input logic [19:0] vpn, input logic [11:0] off,
                      input logic w, input logic eh, input logic [19:0] ep,
                      input logic eu, input logic ed);
    cyc(1, w, {vpn, off}, 0, 20'h0, 20'h0, 0, 0, 0);
    chk(req, eh, ep, off, eu, ed);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn);
    cyc(0, 0, 32'h0, 1, vpn, ppn, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    n_chk++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0) begin
      n_bad++;
      $display("FAIL R11: got v=%b h=%b m=%b exp 0 0 0", rsp_valid, rsp_hit, rsp_miss);
    end

    for (int i = 0; i < 10; i++) begin
      if (VEC[i].refill)
        cyc(0, 0, 32'h0, 1, VEC[i].vpn, VEC[i].ppn, VEC[i].used, VEC[i].dirty, 0);
      else begin
        cyc(1, VEC[i].wr, {VEC[i].vpn, VEC[i].off}, 0, 20'h0, 20'h0, 0, 0, 0);
        chk($sformatf("R1/R3/R4/R5/R8 vec%0d", i), VEC[i].hit, VEC[i].ppn,
            VEC[i].off, VEC[i].used, VEC[i].dirty);
      end
    end

    // R10: refill and lookup in the same cycle
    cyc(1, 0, {20'h00030, 12'h0AA}, 1, 20'h00030, 20'h33333, 0, 1, 0);
    chk("R10 same-cycle refill", 1, 20'h33333, 12'h0AA, 0, 1);
    look("R10 after", 20'h00030, 12'h001, 0, 1, 20'h33333, 1, 1);

    // R9: lookup during flush misses, then everything gone
    cyc(1, 0, {20'h00030, 12'h002}, 0, 20'h0, 20'h0, 0, 0, 1);
    chk("R9 lookup in flush cycle", 0, 20'h0, 12'h0, 0, 0);
    look("R9 after flush", 20'h00020, 12'h003, 0, 0, 20'h0, 0, 0);
    cyc(0, 0, 32'h0, 1, 20'h00041, 20'h44444, 0, 0, 1);
    look("R9 refill dropped", 20'h00041, 12'h004, 0, 0, 20'h0, 0, 0);

    // R6 / R2: fill all 16 from empty, every entry stays live
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00500 + 20'(i));
    for (int i = 0; i < 16; i++)
      look("R2 R6 all entries live", 20'h00100 + 20'(i), 12'(i * 17), 0, 1,
           20'h00500 + 20'(i), 0, 0);

    // R7: LRU eviction
    look("R7 touch 100", 20'h00100, 12'h0, 0, 1, 20'h00500, 1, 0);
    fill(20'h00200, 20'h00600);
    look("R7 101 evicted", 20'h00101, 12'h0, 0, 0, 20'h0, 0, 0);
    look("R7 100 kept", 20'h00100, 12'h0, 0, 1, 20'h00500, 1, 0);
    look("R7 new live", 20'h00200, 12'h0, 0, 1, 20'h00600, 0, 0);
    fill(20'h00201, 20'h00601);
    look("R7 R3 102 evicted", 20'h00102, 12'h0, 0, 0, 20'h0, 0, 0);
    look("R7 103 kept", 20'h00103, 12'h0, 0, 1, 20'h00503, 1, 0);
    look("R7 second new", 20'h00201, 12'h0, 0, 1, 20'h00601, 0, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule